// File: doc/BRIEF.md
# Transmit Byte Queue with Low-Water Ready

This block is the transmit-side buffer of a serial port. A host pushes words into a queue that holds up to 32 bytes. Only the least significant byte of each word is stored. A downstream serializer takes bytes one at a time through a valid/ready handshake. The head byte sits in a one-entry holding register that drives the serializer directly. The remaining bytes wait in a small memory behind it.

The block reports a level-sensitive transmit-ready status. It is high whenever the number of bytes still queued is at or below a programmable low-water level. The count includes the byte in the holding register. The level counts bytes that remain, not free slots. With a level of 8, for example, software that sees the status may safely write 32 − 8 = 24 bytes. An enable input gates the status onto an interrupt line. Software typically drops the enable after servicing and raises it again after refilling.

The block also has these flags:
- a full flag;
- an empty flag, covering both the memory and the holding register;
- a sticky overflow flag for writes that arrive while the queue is full.

Top module: `txq_lowwater`

## Requirements
- R1: After reset the queue is empty: `fifoEmpty`=1, `txValid`=0, `fifoFull`=0, `overflow`=0, and `txRdy`=1 (zero queued is at or below any level).
- R2: Bytes leave on `txData` in the order they were written, and each carries only bits [7:0] of the host word.
- R3: A byte is taken when `txValid` and `txReady` are both high at a rising clock edge. While `txValid` is high and `txReady` is low, `txValid` stays high and `txData` holds its value.
- R4: `txRdy` is high exactly when the queued count is at or below `lowLevel`. The queued count is the memory entries plus the holding register. It follows the count in the cycle after each accepted write or taken byte.
- R5: `txIrq` equals `txRdy` when `irqEn` is 1 and is 0 when `irqEn` is 0.
- R6: A write while 32 bytes are queued is dropped, even if a byte is taken in the same cycle. It sets `overflow`, which stays set until an `ovfClr` pulse clears it. A set has priority over a clear in the same cycle.
- R7: `fifoFull` is high exactly when 32 bytes are queued.
- R8: `fifoEmpty` is high exactly when neither the memory nor the holding register holds a byte.
- R9: A byte written into an empty queue raises `txValid` one cycle after the write edge. This is the clock following the write, not the write edge itself. With `txReady` held high, the queue delivers one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 32 | Host write word; bits [7:0] are queued |
| lowLevel | input | 6 | Low-water level, compared with the queued count |
| irqEn | input | 1 | Interrupt enable |
| ovfClr | input | 1 | Clears the overflow flag |
| txValid | output | 1 | Holding register has a byte for the serializer |
| txReady | input | 1 | Serializer accepts the byte |
| txData | output | 8 | Byte offered to the serializer |
| txRdy | output | 1 | Queued count is at or below `lowLevel` |
| txIrq | output | 1 | `txRdy` gated by `irqEn` |
| fifoFull | output | 1 | 32 bytes queued |
| fifoEmpty | output | 1 | Memory and holding register both empty |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The bench sweeps the threshold boundary, checking queued counts equal to the level and one above it. A design that compared against free slots, or used a strict less-than, would flip `txRdy` on the wrong byte. A design that left the holding register out of the count would assert one byte early while draining from 32 down to 8. A 33rd write is followed by a full drain. This catches a design that overwrote the oldest byte or wrapped a pointer. It also catches a design whose overflow flag cleared itself. A stalled serializer and a write into an empty queue expose a holding register that changed its byte under back-pressure, or that offered data one cycle too early.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Strobes sent from the control block to the datapath each cycle.
  typedef struct packed {
    logic push;  // store the host byte at the write pointer
    logic load;  // move the oldest stored byte into the holding register
  } txq_strobe_t;
endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        txReady,
  input  logic        ovfClr,
  input  logic        irqEn,
  input  logic [CW-1:0] lowLevel,
  output txq_strobe_t stb,
  output logic        txValid,
  output logic        txRdy,
  output logic        txIrq,
  output logic        fifoFull,
  output logic        fifoEmpty,
  output logic        overflow
);
  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);

  logic [CW-1:0] memCount;
  logic          holdFull;
  logic          ovfFlag;
  logic [CW-1:0] queued;
  logic          pop;

  assign queued    = memCount + CW'(holdFull);
  assign fifoFull  = (queued == FULL_COUNT);
  assign fifoEmpty = (queued == '0);
  assign pop       = holdFull && txReady;

  always_comb begin
    stb.push = wrEn && !fifoFull;
    stb.load = (memCount != '0) && (!holdFull || pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCount <= '0;
      holdFull <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      case ({stb.push, stb.load})
        2'b10:   memCount <= memCount + CW'(1);
        2'b01:   memCount <= memCount - CW'(1);
        default: memCount <= memCount;
      endcase
      if (stb.load)  holdFull <= 1'b1;
      else if (pop)  holdFull <= 1'b0;
      if (wrEn && fifoFull) ovfFlag <= 1'b1;
      else if (ovfClr)      ovfFlag <= 1'b0;
    end
  end

  assign txValid  = holdFull;
  assign txRdy    = (queued <= lowLevel);
  assign txIrq    = txRdy && irqEn;
  assign overflow = ovfFlag;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fifoFull) |=> overflow);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    queued <= FULL_COUNT);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !pop) |=> (queued == $past(queued) + CW'(1)));

  // R9
  empty_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |=> !txValid);
endmodule

// File: rtl/txq_data.sv
module txq_data
  import txq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rstN,
  input  txq_strobe_t stb,
  input  logic [7:0]  wrByte,
  input  logic        holdValid,
  input  logic        txReady,
  output logic [7:0]  txData
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [7:0]    holdData;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      holdData <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + AW'(1);
      if (stb.load) begin
        holdData <= mem[rdPtr];
        rdPtr    <= rdPtr + AW'(1);
      end
    end
  end

  assign txData = holdData;

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !txReady) |=> (holdValid && $stable(txData)));
endmodule

// File: rtl/txq_lowwater.sv
module txq_lowwater
  import txq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int HOST_W = 32,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [HOST_W-1:0] wrData,
  input  logic [CW-1:0]     lowLevel,
  input  logic              irqEn,
  input  logic              ovfClr,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txRdy,
  output logic              txIrq,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              overflow
);
  txq_strobe_t stb;
  logic        unusedHostBits;

  assign unusedHostBits = ^wrData[HOST_W-1:8];

  txq_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .txReady(txReady),
    .ovfClr(ovfClr), .irqEn(irqEn), .lowLevel(lowLevel), .stb(stb),
    .txValid(txValid), .txRdy(txRdy), .txIrq(txIrq),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .overflow(overflow)
  );

  txq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(wrData[7:0]),
    .holdValid(txValid), .txReady(txReady), .txData(txData)
  );
endmodule

// File: tb/txq_lowwater_bench.sv
`timescale 1ns/1ps
module txq_lowwater_bench;
  localparam int DEPTH = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [CW-1:0] lowLevel = '0;
  logic irqEn = 1'b0, ovfClr = 1'b0, txReady = 1'b0;
  logic txValid, txRdy, txIrq, fifoFull, fifoEmpty, overflow;
  logic [7:0] txData;

  int total = 0;
  int bad = 0;
  logic [7:0] model[$];

  always #2.5 clk = ~clk;

  txq_lowwater u_txq_lowwater (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .lowLevel(lowLevel), .irqEn(irqEn), .ovfClr(ovfClr),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .txRdy(txRdy), .txIrq(txIrq), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .overflow(overflow)
  );

  // {fill count, level, irqEn, expected txRdy, expected txIrq}
  localparam logic [14:0] VEC [8] = '{
    {6'd0,  6'd0,  1'b1, 1'b1, 1'b1},
    {6'd1,  6'd0,  1'b1, 1'b0, 1'b0},
    {6'd8,  6'd8,  1'b1, 1'b1, 1'b1},
    {6'd9,  6'd8,  1'b1, 1'b0, 1'b0},
    {6'd8,  6'd8,  1'b0, 1'b1, 1'b0},
    {6'd24, 6'd24, 1'b1, 1'b1, 1'b1},
    {6'd32, 6'd31, 1'b1, 1'b0, 1'b0},
    {6'd32, 6'd32, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doRst();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    model.delete();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] w);
    wrEn = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
    if (model.size() < DEPTH) model.push_back(w[7:0]);
  endtask

  task automatic drainAll();
    int guard = 0;
    txReady = 1'b1;
    while (model.size() > 0 && guard < 200) begin
      guard++;
      if (txValid) begin
        chk(txData == model[0], "R2 order", txData, model[0]);
        void'(model.pop_front());
      end
      @(negedge clk);
    end
    txReady = 1'b0;
    chk(guard < 200, "R2 drain finished", guard, 0);
  endtask

  initial begin
    @(negedge clk);
    // R1 reset state
    chk(fifoEmpty && !txValid && !fifoFull && !overflow && txRdy, "R1 reset",
        {fifoEmpty, txValid, fifoFull, overflow, txRdy}, 5'b10001);
    rstN = 1'b1;
    @(negedge clk);

    // Threshold and enable table: R4, R5
    foreach (VEC[i]) begin
      doRst();
      lowLevel = VEC[i][8:3];
      irqEn = VEC[i][2];
      for (int k = 0; k < int'(VEC[i][14:9]); k++) wr(32'h100 + k);
      @(negedge clk);
      @(negedge clk);
      chk(txRdy == VEC[i][1], "R4 txRdy vs level", txRdy, VEC[i][1]);
      chk(txIrq == VEC[i][0], "R5 txIrq gating", txIrq, VEC[i][0]);
    end

    // R9 latency into empty queue, R2 low byte only
    doRst();
    wr(32'hDEAD_BEA5);
    chk(!txValid, "R9 not valid at write edge", txValid, 0);
    @(negedge clk);
    chk(txValid, "R9 valid one cycle later", txValid, 1);
    chk(txData == 8'hA5, "R2 low byte", txData, 8'hA5);

    // R3 stall keeps data
    wr(32'h0000_0133);
    repeat (3) begin
      @(negedge clk);
      chk(txValid && txData == 8'hA5, "R3 stall hold", txData, 8'hA5);
    end
    drainAll();
    chk(fifoEmpty && !txValid, "R8 empty after drain", fifoEmpty, 1);

    // R9 back-to-back throughput
    for (int k = 0; k < 6; k++) wr(32'h50 + k);
    @(negedge clk);
    txReady = 1'b1;
    for (int k = 0; k < 6; k++) begin
      chk(txValid && txData == model[0], "R9 one byte per cycle", txData, model[0]);
      void'(model.pop_front());
      @(negedge clk);
    end
    txReady = 1'b0;
    chk(!txValid && fifoEmpty, "R8 empty after stream", txValid, 0);

    // R4 drain from 32 toward the level of 8, counting the holding register
    doRst();
    lowLevel = 6'd8;
    irqEn = 1'b1;
    for (int k = 0; k < DEPTH; k++) wr(32'h80 + k);
    @(negedge clk);
    @(negedge clk);
    chk(!txRdy, "R4 full above level", txRdy, 0);
    for (int rem = DEPTH - 1; rem >= 0; rem--) begin
      txReady = 1'b1;
      @(negedge clk);
      txReady = 1'b0;
      void'(model.pop_front());
      chk(txRdy == (rem <= 8), "R4 drain threshold", txRdy, rem <= 8);
      @(negedge clk);
    end
    irqEn = 1'b0;
    @(negedge clk);
    chk(txRdy && !txIrq, "R5 enable off", txIrq, 0);

    // R6, R7 overflow and sticky flag
    doRst();
    for (int k = 0; k < DEPTH; k++) wr(32'h40 + k);
    chk(fifoFull, "R7 full at 32", fifoFull, 1);
    chk(!overflow, "R6 no overflow yet", overflow, 0);
    wr(32'hEE);
    chk(overflow, "R6 overflow set", overflow, 1);
    @(negedge clk);
    // write while full with a simultaneous pop is still dropped
    txReady = 1'b1;
    wr(32'hEF);
    txReady = 1'b0;
    void'(model.pop_front());
    chk(!fifoFull, "R6 write during pop dropped", fifoFull, 0);
    drainAll();
    chk(fifoEmpty && !fifoFull, "R8 empty after overflow drain", fifoEmpty, 1);
    chk(overflow, "R6 sticky", overflow, 1);
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    chk(!overflow, "R6 cleared", overflow, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule